// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block connects a 16-bit register bus to an 8-bit raw NAND flash device. A mode register sets the device control lines: chip enable, the command and address latch lines, and a gate that allows writes. All transfers go through a data register. A 16-bit access to it becomes two NAND byte cycles, low byte first. An 8-bit access becomes a single cycle. This lets software issue command and address bytes one at a time and move page data two bytes per bus access.

Each byte cycle holds the write or read strobe low for a fixed number of clocks, set by a parameter. The strobe then stays high for the same number of clocks. The bus is stalled with a wait signal until the last byte cycle has finished.

The ready/busy line from the device is synchronised. Its level can be read as a busy flag. Its rising edge (busy to ready) sets a pending bit. An interrupt output is raised when that pending bit is set and its mask bit is enabled.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset, chip enable is deasserted (`nandCeN`=1), both latch lines are low, both strobes are high, `irqOut` is 0, and the mode register (offset 4) and mask register (offset 7) read 0x00.
- R2: The mode register at byte offset 4 drives the device lines. Bit 4 asserts chip enable (`nandCeN` = NOT bit4), bit 1 drives `nandAle` and bit 0 drives `nandCle`. So 0x94 gives data mode, 0x95 command mode, 0x96 address mode and 0x00 standby.
- R3: With mode bit 7 set, a 16-bit write to offset 0 produces two write cycles. The first carries bits 7:0 and the second bits 15:8. Each cycle holds `nandWeN` low for HOLD_CYC clocks and then high for HOLD_CYC clocks. `busWait` stays high from the request until the clock after the last high phase.
- R4: A 16-bit read of offset 0 produces two read cycles timed the same way on `nandReN`. The first byte read is returned in bits 7:0 and the second in bits 15:8.
- R5: An 8-bit access to offset 0 (`busSize16`=0) produces exactly one byte cycle. A write sends `busWdata[7:0]`; a read returns the byte in bits 7:0 with bits 15:8 zero.
- R6: With mode bit 7 clear, a write to offset 0 is ignored: no write strobe and no wait.
- R7: Bit 7 of the status register (offset 5) reads 1 while `nandRbN` is low (busy), after a two-flop synchroniser. The other bits read 0.
- R8: A low-to-high transition of `nandRbN` sets bit 0 of the interrupt status register (offset 6) on the third clock edge after the input changes. `irqOut` is high when that bit and bit 0 of the mask register (offset 7) are both 1; writing 0x81 to the mask register enables it and 0x00 disables it.
- R9: Writing a 1 to any of bits 3:0 of the interrupt status register clears that bit, so writing 0x0F clears all pending bits and drops `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Access request, held until `busWait` is low at a clock edge |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Byte offset of the register |
| busSize16 | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the addressed register |
| busWait | output | 1 | Stall while the NAND cycles of a data access are in progress |
| irqOut | output | 1 | Ready interrupt |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDataOut | output | 8 | Byte driven to the device |
| nandDataOe | output | 1 | Output enable for `nandDataOut` |
| nandDataIn | input | 8 | Byte returned by the device |
| nandRbN | input | 1 | Ready/busy from the device, low = busy |

## Verification
The hardest situation to reach is the data path during the second byte of a 16-bit transfer. At that point the byte select, the strobe phase counter and the read capture all change together, and an error in any of them shows only in the upper half of the word.

The bench drives the read byte from a counter that advances on every rising edge of the read strobe. A swapped, repeated or missing capture therefore changes the returned word. A queued per-clock model of every strobe, wait and data value catches any phase that is one clock long or short.

The interrupt edge is reached by holding the ready line low across several clocks and then releasing it. The interrupt output is then sampled on both sides of the synchroniser delay.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_MODE   = 3'd4;
  localparam logic [2:0] OFS_STATUS = 3'd5;
  localparam logic [2:0] OFS_IPEND  = 3'd6;
  localparam logic [2:0] OFS_IMASK  = 3'd7;

  // control -> datapath strobes
  typedef struct packed {
    logic loadWr;
    logic capLo;
    logic capHi;
    logic selHi;
    logic drive;
  } ctlStrobe_t;

  // decoded mode bits used outside the datapath
  typedef struct packed {
    logic weEn;
    logic ceOn;
    logic aleOn;
    logic cleOn;
  } modeLines_t;
endpackage

// File: rtl/nand_bridge_dp.sv
module nand_bridge_dp
  import nand_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWr,
  input  logic [2:0]        busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  ctlStrobe_t        strobe,
  input  logic [BYTE_W-1:0] nandDataIn,
  input  logic              nandRbN,
  output modeLines_t        modeLines,
  output logic [WORD_W-1:0] busRdata,
  output logic [BYTE_W-1:0] nandDataOut,
  output logic              nandDataOe,
  output logic              irqOut
);
  localparam int PEND_W = 4;

  logic [BYTE_W-1:0] modeQ, maskQ;
  logic [PEND_W-1:0] pendQ;
  logic [WORD_W-1:0] wrLatch, rdLatch;
  logic              rbS1, rbS2, rbPrev;
  logic              regWr, readyRise;

  assign regWr     = busReq && busWr && (busAddr != OFS_DATA);
  assign readyRise = rbS2 && !rbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbS1   <= 1'b1;
      rbS2   <= 1'b1;
      rbPrev <= 1'b1;
    end else begin
      rbS1   <= nandRbN;
      rbS2   <= rbS1;
      rbPrev <= rbS2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      maskQ <= '0;
      pendQ <= '0;
    end else begin
      if (regWr && busAddr == OFS_MODE)  modeQ <= busWdata[BYTE_W-1:0];
      if (regWr && busAddr == OFS_IMASK) maskQ <= busWdata[BYTE_W-1:0];
      for (int i = 0; i < PEND_W; i++) begin
        if (i == 0 && readyRise)
          pendQ[i] <= 1'b1;
        else if (regWr && busAddr == OFS_IPEND && busWdata[i])
          pendQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrLatch <= '0;
      rdLatch <= '0;
    end else begin
      if (strobe.loadWr) begin
        wrLatch <= busWdata;
        rdLatch <= '0;
      end
      if (strobe.capLo) rdLatch[BYTE_W-1:0]      <= nandDataIn;
      if (strobe.capHi) rdLatch[WORD_W-1:BYTE_W] <= nandDataIn;
    end
  end

  assign nandDataOut = strobe.selHi ? wrLatch[WORD_W-1:BYTE_W] : wrLatch[BYTE_W-1:0];
  assign nandDataOe  = strobe.drive;
  assign irqOut      = pendQ[0] && maskQ[0];

  assign modeLines.weEn  = modeQ[7];
  assign modeLines.ceOn  = modeQ[4];
  assign modeLines.aleOn = modeQ[1];
  assign modeLines.cleOn = modeQ[0];

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_DATA:   busRdata = rdLatch;
      OFS_MODE:   busRdata[BYTE_W-1:0] = modeQ;
      OFS_STATUS: busRdata[7] = !rbS2;
      OFS_IPEND:  busRdata[PEND_W-1:0] = pendQ;
      OFS_IMASK:  busRdata[BYTE_W-1:0] = maskQ;
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/nand_bridge_ctl.sv
module nand_bridge_ctl
  import nand_bridge_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic       busSize16,
  input  logic       modeWe,
  output logic       busWait,
  output logic       nandWeN,
  output logic       nandReN,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_DONE} phase_t;

  phase_t           state;
  logic [CNT_W-1:0] cnt;
  logic             hiByte, isWrite, twoBytes, dataHit, phaseEnd;

  assign dataHit  = busReq && (busAddr == OFS_DATA) && (!busWr || modeWe);
  assign phaseEnd = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      hiByte   <= 1'b0;
      isWrite  <= 1'b0;
      twoBytes <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (dataHit) begin
          state    <= ST_LOW;
          cnt      <= '0;
          hiByte   <= 1'b0;
          isWrite  <= busWr;
          twoBytes <= busSize16;
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state <= ST_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            cnt <= '0;
            if (twoBytes && !hiByte) begin
              hiByte <= 1'b1;
              state  <= ST_LOW;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busWait = dataHit && (state != ST_DONE);
  assign nandWeN = !(state == ST_LOW && isWrite);
  assign nandReN = !(state == ST_LOW && !isWrite);

  assign strobe.loadWr = (state == ST_IDLE) && dataHit;
  assign strobe.capLo  = (state == ST_LOW) && phaseEnd && !isWrite && !hiByte;
  assign strobe.capHi  = (state == ST_LOW) && phaseEnd && !isWrite && hiByte;
  assign strobe.selHi  = hiByte;
  assign strobe.drive  = isWrite && (state == ST_LOW || state == ST_HIGH);
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nand_bridge_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic        busSize16,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        busWait,
  output logic        irqOut,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandDataOut,
  output logic        nandDataOe,
  input  logic [7:0]  nandDataIn,
  input  logic        nandRbN
);
  ctlStrobe_t strobe;
  modeLines_t modeLines;

  nand_bridge_ctl #(.HOLD_CYC(HOLD_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busSize16(busSize16), .modeWe(modeLines.weEn), .busWait(busWait),
    .nandWeN(nandWeN), .nandReN(nandReN), .strobe(strobe)
  );

  nand_bridge_dp u_dp (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .nandDataIn(nandDataIn),
    .nandRbN(nandRbN), .modeLines(modeLines), .busRdata(busRdata),
    .nandDataOut(nandDataOut), .nandDataOe(nandDataOe), .irqOut(irqOut)
  );

  assign nandCeN = !modeLines.ceOn;
  assign nandCle = modeLines.cleOn;
  assign nandAle = modeLines.aleOn;
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk (
  input logic clk,
  input logic rstN,
  input logic nandWeN,
  input logic nandReN,
  input logic busWait,
  input logic nandDataOe,
  input logic modeWeBit
);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandWeN == 1'b0 && nandReN == 1'b0));

  // R3
  we_stalls_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> busWait);

  // R4
  re_stalls_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> busWait);

  // R6
  we_needs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> modeWeBit);

  // R3
  we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDataOe);
endmodule

bind nand_bus_bridge nand_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .nandWeN(nandWeN), .nandReN(nandReN),
  .busWait(busWait), .nandDataOe(nandDataOe), .modeWeBit(modeLines.weEn)
);

// File: tb/nand_bus_bridge_tb.sv
module nand_bus_bridge_tb;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWr = 1'b0, busSize16 = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        busWait, irqOut, nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDataOe;
  logic [7:0]  nandDataOut, nandDataIn;
  logic        nandRbN = 1'b1;

  int checks = 0, fails = 0;
  int rdIdx = 0;
  bit running = 1'b0;
  logic [7:0] expMode = 8'h00;

  typedef struct packed {
    logic       waitQ;
    logic       weN;
    logic       reN;
    logic [7:0] dout;
    logic       chkData;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  nand_bus_bridge #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busSize16(busSize16), .busWdata(busWdata), .busRdata(busRdata),
    .busWait(busWait), .irqOut(irqOut), .nandCeN(nandCeN), .nandCle(nandCle),
    .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDataOut(nandDataOut), .nandDataOe(nandDataOe),
    .nandDataIn(nandDataIn), .nandRbN(nandRbN)
  );

  function automatic logic [7:0] flashByte(int i);
    return 8'(8'h3C + i * 29);
  endfunction

  assign nandDataIn = flashByte(rdIdx);
  always @(posedge nandReN) rdIdx++;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) if (running) begin
    exp_t e;
    if (expQ.size() > 0) e = expQ.pop_front();
    else e = '{waitQ: 1'b0, weN: 1'b1, reN: 1'b1, dout: 8'h0, chkData: 1'b0};
    check(busWait == e.waitQ, "R3 busWait", busWait, e.waitQ);
    check(nandWeN == e.weN, "R3/R6 nandWeN", nandWeN, e.weN);
    check(nandReN == e.reN, "R4 nandReN", nandReN, e.reN);
    if (e.chkData) check(nandDataOut == e.dout, "R3/R5 nandDataOut", nandDataOut, e.dout);
    check(nandCeN == !expMode[4], "R2 nandCeN", nandCeN, !expMode[4]);
    check(nandCle == expMode[0], "R2 nandCle", nandCle, expMode[0]);
    check(nandAle == expMode[1], "R2 nandAle", nandAle, expMode[1]);
  end

  task automatic regWrite(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busReq = 1; busWr = 1; busAddr = a; busSize16 = 0; busWdata = {8'h00, d};
    @(posedge clk);
    if (a == 3'd4) expMode = d;
    #1 busReq = 0; busWr = 0;
  endtask

  task automatic regRead(logic [2:0] a, logic [15:0] exp, string tag);
    @(posedge clk); #1;
    busReq = 1; busWr = 0; busAddr = a; busSize16 = 0;
    @(negedge clk);
    check(busRdata == exp, tag, busRdata, exp);
    @(posedge clk); #1 busReq = 0;
  endtask

  task automatic dataAcc(bit wr, bit sz16, logic [15:0] wd, string tag);
    int n = sz16 ? 2 : 1;
    logic [15:0] expRd = sz16 ? {flashByte(rdIdx + 1), flashByte(rdIdx)} : {8'h00, flashByte(rdIdx)};
    @(posedge clk); #1;
    busReq = 1; busWr = wr; busAddr = 0; busSize16 = sz16; busWdata = wd;
    expQ.push_back('{1'b1, 1'b1, 1'b1, 8'h0, 1'b0});
    for (int b = 0; b < n; b++) begin
      for (int h = 0; h < HOLD; h++)
        expQ.push_back('{1'b1, !wr, wr, (b == 0) ? wd[7:0] : wd[15:8], wr});
      for (int h = 0; h < HOLD; h++)
        expQ.push_back('{1'b1, 1'b1, 1'b1, 8'h0, 1'b0});
    end
    expQ.push_back('{1'b0, 1'b1, 1'b1, 8'h0, 1'b0});
    while (expQ.size() != 0) @(posedge clk);
    #1;
    if (!wr) check(busRdata == expRd, tag, busRdata, expRd);
    busReq = 0; busWr = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    rdIdx = 0;
    running = 1;
    // R1 reset state
    @(negedge clk);
    check(irqOut == 0, "R1 irqOut", irqOut, 0);
    check(nandCeN == 1, "R1 nandCeN", nandCeN, 1);
    regRead(3'd4, 16'h0000, "R1 mode reset");
    regRead(3'd7, 16'h0000, "R1 mask reset");

    // R2 mode lines
    regWrite(3'd4, 8'h95); regRead(3'd4, 16'h0095, "R2 command mode");
    regWrite(3'd4, 8'h96); regRead(3'd4, 16'h0096, "R2 address mode");
    regWrite(3'd4, 8'h94);
    regWrite(3'd4, 8'h00); regRead(3'd4, 16'h0000, "R2 standby");

    // R5 single command byte
    regWrite(3'd4, 8'h95);
    dataAcc(1, 0, 16'h12FF, "R5 command write");
    regWrite(3'd4, 8'h96);
    dataAcc(1, 0, 16'h0000, "R5 address write");

    // R3 16-bit writes
    regWrite(3'd4, 8'h94);
    dataAcc(1, 1, 16'h5AC3, "R3 word write");
    dataAcc(1, 1, 16'hFF00, "R3 word write 2");

    // R4 and R5 reads
    dataAcc(0, 1, 16'h0, "R4 word read");
    dataAcc(0, 1, 16'h0, "R4 word read 2");
    dataAcc(0, 0, 16'h0, "R5 byte read");

    // R6 gated write
    regWrite(3'd4, 8'h14);
    @(posedge clk); #1;
    busReq = 1; busWr = 1; busAddr = 0; busSize16 = 1; busWdata = 16'hBEEF;
    @(negedge clk);
    check(busWait == 0, "R6 no wait", busWait, 0);
    repeat (2) @(posedge clk);
    #1 busReq = 0; busWr = 0;
    repeat (2) @(negedge clk);
    check(nandWeN == 1, "R6 no strobe", nandWeN, 1);

    // R7 busy status
    regWrite(3'd6, 8'h0F);
    @(posedge clk); #1 nandRbN = 0;
    repeat (3) @(posedge clk);
    regRead(3'd5, 16'h0080, "R7 busy");
    regRead(3'd6, 16'h0000, "R8 no pend while busy");

    // R8 ready edge
    regWrite(3'd7, 8'h81);
    @(posedge clk); #1 nandRbN = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(irqOut == 0, "R8 irq before sync", irqOut, 0);
    @(posedge clk);
    @(negedge clk);
    check(irqOut == 1, "R8 irq raised", irqOut, 1);
    regRead(3'd5, 16'h0000, "R7 ready");
    regRead(3'd6, 16'h0001, "R8 pend bit");
    regWrite(3'd7, 8'h00);
    @(negedge clk);
    check(irqOut == 0, "R8 masked", irqOut, 0);
    regRead(3'd6, 16'h0001, "R8 pend kept when masked");
    regWrite(3'd7, 8'h81);
    @(negedge clk);
    check(irqOut == 1, "R8 unmasked", irqOut, 1);

    // R9 clear
    regWrite(3'd6, 8'h0F);
    @(negedge clk);
    check(irqOut == 0, "R9 irq cleared", irqOut, 0);
    regRead(3'd6, 16'h0000, "R9 pend cleared");

    repeat (3) @(posedge clk);
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule